// File: doc/BRIEF.md
# Delayed-Read Bridge Controller

This block answers host-bus reads aimed at a remote PCI target by the delayed-read method. When a read arrives and nothing is pending, the controller records the address and qualifiers and tells the host to rearbitrate. No error is flagged. It then places one translated read request on a simple PCI-side initiator interface and stores the returned 32-bit words in a small prefetch buffer. The host keeps re-issuing the read. Once the data is buffered, only a re-issued read with the same address, length, burst flag and space type gets the data, as a run of consecutive beats.

While a read is outstanding, every other host read gets a rearbitrate. A PCI-side retry makes the controller re-issue the same PCI request. A PCI-side abort drops the transfer, and the next identical host read is answered with an error. A discard timer limits how long buffered data waits for the host. When it expires, the data is dropped and the controller becomes free for a new read.

The PCI command code comes from the space type and the burst flag. The PCI address comes from a per-window substitution of the high-order address bits. The word count comes from the host's encoded burst length, capped at the buffer depth.

Top module: `dlyrd_bridge`

## Requirements
- R1: A host read (`h_req`=1 at a clock edge) that arrives while nothing is pending is answered one cycle later by `h_rearb`=1, with `h_ack`=0 and `h_err`=0, and `p_req` rises in that same cycle.
- R2: `p_cmd` is 4'b0010 when `h_io`=1 (I/O read), 4'b0110 for memory space with `h_burst`=0 (memory read), and 4'b1100 for memory space with `h_burst`=1 (memory read multiple).
- R3: The top HI_W address bits (default 4) select a window i. They are replaced by the 4-bit field at bits [4i+3:4i] of XLAT_MAP (default: value 15-i). Bits [1:0] of `p_addr` are 00 for memory space and copy `h_addr[1:0]` for I/O space. The remaining bits pass through.
- R4: `p_len` is 1 for a non-burst read. For a burst read it is `h_blen`+1, capped at DEPTH (default 8). The delivered burst has exactly `p_len` beats, with `h_rd_last` on the final beat.
- R5: `p_be` is 4'hF for any burst read, and the latched `h_be` for a non-burst read.
- R6: A host read that arrives while a PCI request is issued, being fetched or being delivered, or while data is buffered for a different read, gets `h_rearb` one cycle later and leaves the buffered data unchanged. At most one of `h_ack`, `h_rearb` and `h_err` is high in any cycle.
- R7: When data is buffered, a host read that matches the latched `h_addr`, `h_blen`, `h_burst` and `h_io` exactly gets `h_ack` one cycle later. The buffered words appear on `h_rd_data` in fetch order, one per cycle, starting in the `h_ack` cycle. `h_be` takes no part in the match.
- R8: The buffered data stays available for exactly DISCARD_CYC (default 16) clock edges after the PCI side reports done. A matching read sampled at the last of those edges is served. At any later edge, the same read starts a new fetch (R1).
- R9: `p_req` is high for exactly one cycle per issue. A `p_retry` during the fetch makes `p_req` rise again one cycle later and restarts word collection. The host still sees only rearbitrates.
- R10: A `p_abort` during the fetch frees the controller. The next identical host read gets `h_err` one cycle later with no PCI request. After that, the read starts a new fetch. A different read instead starts a new fetch at once and clears the error.
- R11: While `rst_n` is low at a clock edge, `h_ack`, `h_rearb`, `h_err`, `h_rd_valid`, `h_rd_last` and `p_req` are 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_req | input | 1 | Host read request, one cycle per attempt |
| h_addr | input | AW | Host read address |
| h_blen | input | LW | Encoded burst length (words minus one) |
| h_burst | input | 1 | Burst read flag |
| h_io | input | 1 | 1 = I/O space, 0 = memory space |
| h_be | input | 4 | Byte enables for a single read |
| h_ack | output | 1 | Read accepted, data beats start |
| h_rearb | output | 1 | Host must rearbitrate and retry |
| h_err | output | 1 | Read failed on the PCI side |
| h_rd_valid | output | 1 | Read data beat valid |
| h_rd_data | output | DW | Read data |
| h_rd_last | output | 1 | Final read beat |
| p_req | output | 1 | PCI read request, one cycle |
| p_cmd | output | 4 | PCI command code |
| p_addr | output | AW | Translated PCI address |
| p_len | output | $clog2(DEPTH+1) | Words to fetch |
| p_be | output | 4 | PCI byte enables |
| p_dvalid | input | 1 | Returned PCI data word valid |
| p_data | input | DW | Returned PCI data word |
| p_done | input | 1 | PCI transfer completed |
| p_retry | input | 1 | PCI target asked for a retry |
| p_abort | input | 1 | PCI master or target abort |

## Verification
The bench goes after the discard boundary by placing the matching read on the last edge of the hold window and again one edge later. A timer that is off by one either serves stale data or refuses a legal read. It sends a burst longer than the buffer, where a missing cap would overrun the buffer or emit too many beats. It also sends reads that differ only in length or address while data is buffered: a loose match would deliver wrong data, and a careless latch would corrupt the buffer. Finally it drives a PCI retry after one word has already arrived, where a stale word count would shift the delivered words. It drives an abort followed by identical and different reads, where a lost error flag would restart silently and a sticky one would block the new fetch.

// File: rtl/dlyrd_pkg.sv
// Shared types for the delayed-read bridge controller.
// Assumes PCI command codes on a 4-bit bus.
package dlyrd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_FETCH,
        ST_READY,
        ST_DELIVER
    } dr_state_t;

    localparam logic [3:0] CMD_IO_RD       = 4'b0010;
    localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
    localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
endpackage

// File: rtl/dlyrd_xlate.sv
// Request translation: turns latched host qualifiers into the PCI command,
// the translated address, the word count and the byte enables.
// Assumes AW > HI_W + 2 and a 4-bit byte-enable field.
module dlyrd_xlate #(
    parameter int AW       = 32,
    parameter int LW       = 4,
    parameter int DEPTH    = 8,
    parameter int HI_W     = 4,
    parameter logic [(2**HI_W)*HI_W-1:0] XLAT_MAP = 64'h0123_4567_89AB_CDEF,
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int NWIN    = 2**HI_W
) (
    input  logic [AW-1:0]    addr,
    input  logic [LW-1:0]    blen,
    input  logic             burst,
    input  logic             io,
    input  logic [3:0]       be,
    output logic [3:0]       cmd,
    output logic [AW-1:0]    paddr,
    output logic [CNT_W-1:0] len,
    output logic [3:0]       be_o
);
    import dlyrd_pkg::*;

    logic [HI_W-1:0] xtab [NWIN];
    logic [31:0]     want;

    // Unpack the per-window substitution values.
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        assign xtab[g] = XLAT_MAP[g*HI_W +: HI_W];
    end

    // Command from space type and burst flag.
    always_comb begin
        if (io)         cmd = CMD_IO_RD;
        else if (burst) cmd = CMD_MEM_RD_MULT;
        else            cmd = CMD_MEM_RD;
    end

    // Address substitution with low-bit handling per space.
    always_comb begin
        paddr = {xtab[addr[AW-1 -: HI_W]], addr[AW-HI_W-1:2], io ? addr[1:0] : 2'b00};
    end

    // Word count, capped at the buffer depth.
    always_comb begin
        want = burst ? (32'(blen) + 32'd1) : 32'd1;
        len  = CNT_W'((want > 32'(DEPTH)) ? 32'(DEPTH) : want);
    end

    // Byte enables: all lanes on a burst.
    always_comb begin
        be_o = burst ? 4'hF : be;
    end
endmodule

// File: rtl/dlyrd_pbuf.sv
// Prefetch buffer: DEPTH words, one write port, one asynchronous read port.
// Assumes the writer never addresses beyond DEPTH-1. Contents are not reset.
module dlyrd_pbuf #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // One storage register per entry.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (we && waddr == IW'(i)) mem[i] <= wdata;
        end
    end

    // Read port.
    assign rdata = mem[raddr];
endmodule

// File: rtl/dlyrd_dtimer.sv
// Discard timer: counts cycles while run is high and clears when run is low.
// expire marks the last cycle the buffered data may still be claimed.
// Assumes DISC >= 1.
module dlyrd_dtimer #(
    parameter int DISC  = 16,
    localparam int TW   = $clog2(DISC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    logic [TW-1:0] cnt;

    // Age counter, held at zero outside the holding state.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (!run)    cnt <= '0;
        else if (!expire) cnt <= cnt + 1'b1;
    end

    assign expire = (cnt == TW'(DISC - 1));
endmodule

// File: rtl/dlyrd_bridge.sv
// Delayed-read bridge controller. It answers host reads for a PCI target
// with rearbitrate, prefetches in the background, and hands the buffered
// words to an identical re-issued read. Stale data is discarded by a timer.
// Assumes one host attempt per h_req pulse and a PCI side that reports
// done, retry or abort with single-cycle pulses after p_req.
module dlyrd_bridge #(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int LW          = 4,
    parameter int DEPTH       = 8,
    parameter int DISCARD_CYC = 16,
    parameter int HI_W        = 4,
    parameter logic [(2**HI_W)*HI_W-1:0] XLAT_MAP = 64'h0123_4567_89AB_CDEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       h_req,
    input  logic [AW-1:0]              h_addr,
    input  logic [LW-1:0]              h_blen,
    input  logic                       h_burst,
    input  logic                       h_io,
    input  logic [3:0]                 h_be,
    output logic                       h_ack,
    output logic                       h_rearb,
    output logic                       h_err,
    output logic                       h_rd_valid,
    output logic [DW-1:0]              h_rd_data,
    output logic                       h_rd_last,
    output logic                       p_req,
    output logic [3:0]                 p_cmd,
    output logic [AW-1:0]              p_addr,
    output logic [$clog2(DEPTH+1)-1:0] p_len,
    output logic [3:0]                 p_be,
    input  logic                       p_dvalid,
    input  logic [DW-1:0]              p_data,
    input  logic                       p_done,
    input  logic                       p_retry,
    input  logic                       p_abort
);
    import dlyrd_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    dr_state_t        st;
    logic [AW-1:0]    lat_addr;
    logic [LW-1:0]    lat_blen;
    logic             lat_burst;
    logic             lat_io;
    logic [3:0]       lat_be;
    logic             err_pend;
    logic [CNT_W-1:0] wcnt;
    logic [CNT_W-1:0] rcnt;
    logic [CNT_W-1:0] x_len;
    logic             hit;
    logic             take;
    logic             expire;
    logic             last_beat;
    logic [DW-1:0]    rdata;

    dlyrd_xlate #(
        .AW(AW), .LW(LW), .DEPTH(DEPTH), .HI_W(HI_W), .XLAT_MAP(XLAT_MAP)
    ) u_xlate (
        .addr(lat_addr), .blen(lat_blen), .burst(lat_burst), .io(lat_io),
        .be(lat_be), .cmd(p_cmd), .paddr(p_addr), .len(x_len), .be_o(p_be)
    );

    dlyrd_pbuf #(.DW(DW), .DEPTH(DEPTH)) u_pbuf (
        .clk(clk), .we(take), .waddr(wcnt[IW-1:0]), .wdata(p_data),
        .raddr(rcnt[IW-1:0]), .rdata(rdata)
    );

    dlyrd_dtimer #(.DISC(DISCARD_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(st == ST_READY), .expire(expire)
    );

    // Exact match of a host read against the latched request.
    assign hit = h_req && (h_addr == lat_addr) && (h_blen == lat_blen)
              && (h_burst == lat_burst) && (h_io == lat_io);

    // A returned word is stored while room remains and no abort or retry.
    assign take = (st == ST_FETCH) && p_dvalid && !p_abort && !p_retry
               && (wcnt < x_len);

    assign last_beat  = (rcnt == x_len - 1'b1);
    assign p_req      = (st == ST_ISSUE);
    assign p_len      = x_len;
    assign h_rd_valid = (st == ST_DELIVER);
    assign h_rd_last  = (st == ST_DELIVER) && last_beat;
    assign h_rd_data  = (st == ST_DELIVER) ? rdata : '0;

    // Main sequencer: host responses, fetch progress and delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            h_ack     <= 1'b0;
            h_rearb   <= 1'b0;
            h_err     <= 1'b0;
            err_pend  <= 1'b0;
            wcnt      <= '0;
            rcnt      <= '0;
            lat_addr  <= '0;
            lat_blen  <= '0;
            lat_burst <= 1'b0;
            lat_io    <= 1'b0;
            lat_be    <= '0;
        end else begin
            h_ack   <= 1'b0;
            h_rearb <= 1'b0;
            h_err   <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (h_req) begin
                        err_pend <= 1'b0;
                        if (err_pend && hit) begin
                            h_err <= 1'b1;
                        end else begin
                            lat_addr  <= h_addr;
                            lat_blen  <= h_blen;
                            lat_burst <= h_burst;
                            lat_io    <= h_io;
                            lat_be    <= h_be;
                            h_rearb   <= 1'b1;
                            st        <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (h_req) h_rearb <= 1'b1;
                    wcnt <= '0;
                    st   <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (h_req) h_rearb <= 1'b1;
                    if (p_abort) begin
                        err_pend <= 1'b1;
                        st       <= ST_IDLE;
                    end else if (p_retry) begin
                        st <= ST_ISSUE;
                    end else begin
                        if (take)   wcnt <= wcnt + 1'b1;
                        if (p_done) st   <= ST_READY;
                    end
                end
                ST_READY: begin
                    if (hit) begin
                        h_ack <= 1'b1;
                        rcnt  <= '0;
                        st    <= ST_DELIVER;
                    end else begin
                        if (h_req)  h_rearb <= 1'b1;
                        if (expire) st      <= ST_IDLE;
                    end
                end
                ST_DELIVER: begin
                    if (h_req) h_rearb <= 1'b1;
                    if (last_beat) st   <= ST_IDLE;
                    else           rcnt <= rcnt + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dlyrd_chk.sv
// Property checker for the delayed-read bridge controller, bound to the top.
// Observes ports only.
module dlyrd_chk #(
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             h_req,
    input logic             h_ack,
    input logic             h_rearb,
    input logic             h_err,
    input logic             h_rd_valid,
    input logic             h_rd_last,
    input logic             p_req,
    input logic [3:0]       p_cmd,
    input logic [1:0]       p_addr_lo,
    input logic [CNT_W-1:0] p_len,
    input logic [3:0]       p_be
);
    import dlyrd_pkg::*;

    a_r6_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({h_ack, h_rearb, h_err}));

    a_r9_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        p_req |=> !p_req);

    a_r2_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
        p_req |-> (p_cmd == CMD_IO_RD || p_cmd == CMD_MEM_RD || p_cmd == CMD_MEM_RD_MULT));

    a_r3_mem_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req && p_cmd != CMD_IO_RD) |-> (p_addr_lo == 2'b00));

    a_r5_burst_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req && p_cmd == CMD_MEM_RD_MULT) |-> (p_be == 4'hF));

    a_r4_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        p_req |-> (p_len != '0 && p_len <= CNT_W'(DEPTH)));

    a_r7_ack_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        h_ack |-> h_rd_valid);

    a_r7_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        h_ack |-> $past(h_req));

    a_r4_last_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
        h_rd_last |-> h_rd_valid);

    a_r4_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        h_rd_last |=> !h_rd_valid);

    a_r7_beats_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd_valid && !h_rd_last) |=> h_rd_valid);
endmodule

bind dlyrd_bridge dlyrd_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_ack(h_ack), .h_rearb(h_rearb),
    .h_err(h_err), .h_rd_valid(h_rd_valid), .h_rd_last(h_rd_last),
    .p_req(p_req), .p_cmd(p_cmd), .p_addr_lo(p_addr[1:0]), .p_len(p_len),
    .p_be(p_be)
);

// File: tb/sim_dlyrd_bridge.sv
module sim_dlyrd_bridge;
    localparam int DISC  = 16;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_req = 1'b0;
    logic [31:0] h_addr = '0;
    logic [3:0]  h_blen = '0;
    logic        h_burst = 1'b0;
    logic        h_io = 1'b0;
    logic [3:0]  h_be = '0;
    logic        h_ack, h_rearb, h_err, h_rd_valid, h_rd_last;
    logic [31:0] h_rd_data;
    logic        p_req;
    logic [3:0]  p_cmd;
    logic [31:0] p_addr;
    logic [3:0]  p_len;
    logic [3:0]  p_be;
    logic        p_dvalid = 1'b0;
    logic [31:0] p_data = '0;
    logic        p_done = 1'b0;
    logic        p_retry = 1'b0;
    logic        p_abort = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #10 clk = ~clk;

    dlyrd_bridge u0 (
        .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_addr(h_addr), .h_blen(h_blen),
        .h_burst(h_burst), .h_io(h_io), .h_be(h_be), .h_ack(h_ack), .h_rearb(h_rearb),
        .h_err(h_err), .h_rd_valid(h_rd_valid), .h_rd_data(h_rd_data),
        .h_rd_last(h_rd_last), .p_req(p_req), .p_cmd(p_cmd), .p_addr(p_addr),
        .p_len(p_len), .p_be(p_be), .p_dvalid(p_dvalid), .p_data(p_data),
        .p_done(p_done), .p_retry(p_retry), .p_abort(p_abort)
    );

    task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got %0h exp %0h at cycle %0d", tag, what, got, exp, cyc);
        end
    endtask

    // Expected values from the requirements.
    function automatic int exp_len(logic [3:0] bl, logic bu);
        int w;
        w = bu ? int'(bl) + 1 : 1;
        return (w > DEPTH) ? DEPTH : w;
    endfunction

    function automatic logic [3:0] exp_cmd(logic io, logic bu);
        if (io) return 4'b0010;
        return bu ? 4'b1100 : 4'b0110;
    endfunction

    function automatic logic [31:0] exp_addr(logic [31:0] a, logic io);
        logic [3:0] w;
        w = 4'd15 - a[31:28];
        return {w, a[27:2], io ? a[1:0] : 2'b00};
    endfunction

    // Behavioural reference: phase number, queues of words, a hold counter.
    int          m_ph = 0;
    int          m_tcnt = 0;
    bit          m_err = 0;
    logic [31:0] m_addr = '0;
    logic [3:0]  m_blen = '0;
    logic        m_burst = 0, m_io = 0;
    logic [3:0]  m_be = '0;
    logic [31:0] m_wq[$];
    logic [31:0] m_dq[$];
    bit          e_ack = 0, e_rearb = 0, e_err = 0;

    always @(posedge clk) begin
        bit hit;
        cyc++;
        if (!rst_n) begin
            m_ph = 0; m_err = 0; m_tcnt = 0;
            m_addr = '0; m_blen = '0; m_burst = 0; m_io = 0; m_be = '0;
            e_ack = 0; e_rearb = 0; e_err = 0;
            m_wq.delete(); m_dq.delete();
        end else begin
            e_ack = 0; e_rearb = 0; e_err = 0;
            hit = h_req && h_addr == m_addr && h_blen == m_blen
                  && h_burst == m_burst && h_io == m_io;
            case (m_ph)
                0: if (h_req) begin
                       if (m_err && hit) e_err = 1;
                       else begin
                           m_addr = h_addr; m_blen = h_blen; m_burst = h_burst;
                           m_io = h_io; m_be = h_be; e_rearb = 1; m_ph = 1;
                       end
                       m_err = 0;
                   end
                1: begin
                       if (h_req) e_rearb = 1;
                       m_wq.delete();
                       m_ph = 2;
                   end
                2: begin
                       if (h_req) e_rearb = 1;
                       if (p_abort) begin m_ph = 0; m_err = 1; end
                       else if (p_retry) m_ph = 1;
                       else begin
                           if (p_dvalid && m_wq.size() < exp_len(m_blen, m_burst))
                               m_wq.push_back(p_data);
                           if (p_done) begin m_ph = 3; m_tcnt = 0; end
                       end
                   end
                3: if (hit) begin
                       e_ack = 1; m_dq = m_wq; m_ph = 4;
                   end else begin
                       if (h_req) e_rearb = 1;
                       if (m_tcnt == DISC - 1) m_ph = 0;
                       else m_tcnt++;
                   end
                default: begin
                       if (h_req) e_rearb = 1;
                       void'(m_dq.pop_front());
                       if (m_dq.size() == 0) m_ph = 0;
                   end
            endcase
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1", "h_rearb", 64'(h_rearb), 64'(e_rearb));
            chk("R7", "h_ack", 64'(h_ack), 64'(e_ack));
            chk("R10", "h_err", 64'(h_err), 64'(e_err));
            chk("R9", "p_req", 64'(p_req), 64'(m_ph == 1));
            chk("R7", "h_rd_valid", 64'(h_rd_valid), 64'(m_ph == 4));
            if (m_ph == 4) begin
                chk("R7", "h_rd_data", 64'(h_rd_data), 64'(m_dq[0]));
                chk("R4", "h_rd_last", 64'(h_rd_last), 64'(m_dq.size() == 1));
            end
            if (m_ph == 1) begin
                chk("R2", "p_cmd", 64'(p_cmd), 64'(exp_cmd(m_io, m_burst)));
                chk("R3", "p_addr", 64'(p_addr), 64'(exp_addr(m_addr, m_io)));
                chk("R4", "p_len", 64'(p_len), 64'(exp_len(m_blen, m_burst)));
                chk("R5", "p_be", 64'(p_be), 64'(m_burst ? 4'hF : m_be));
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic hreq(logic [31:0] a, logic [3:0] bl, logic bu, logic io, logic [3:0] be);
        @(negedge clk); #2;
        h_req = 1; h_addr = a; h_blen = bl; h_burst = bu; h_io = io; h_be = be;
        @(negedge clk); #2;
        h_req = 0;
    endtask

    task automatic pwait();
        while (p_req !== 1'b1) @(negedge clk);
    endtask

    task automatic pword(logic [31:0] d);
        @(negedge clk); #2; p_dvalid = 1; p_data = d;
        @(negedge clk); #2; p_dvalid = 0;
    endtask

    task automatic pdone();
        @(negedge clk); #2; p_done = 1;
        @(negedge clk); #2; p_done = 0;
    endtask

    task automatic pretry();
        @(negedge clk); #2; p_retry = 1;
        @(negedge clk); #2; p_retry = 0;
    endtask

    task automatic pabort();
        @(negedge clk); #2; p_abort = 1;
        @(negedge clk); #2; p_abort = 0;
    endtask

    task automatic pserve(int n, logic [31:0] base);
        for (int i = 0; i < n; i++) pword(base + 32'(i));
        pdone();
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        // R11: outputs quiet under reset.
        chk("R11", "h_ack", 64'(h_ack), 0);
        chk("R11", "h_rearb", 64'(h_rearb), 0);
        chk("R11", "h_err", 64'(h_err), 0);
        chk("R11", "h_rd_valid", 64'(h_rd_valid), 0);
        chk("R11", "h_rd_last", 64'(h_rd_last), 0);
        chk("R11", "p_req", 64'(p_req), 0);
        #2 rst_n = 1;

        // R1: single memory read, partial byte enables.
        hreq(32'h4000_1236, 4'd0, 0, 0, 4'h3);
        chk("R1", "first read rearb", 64'(h_rearb), 1);
        chk("R1", "first read p_req", 64'(p_req), 1);
        pwait(); pserve(1, 32'h1111_0000);
        idle(2);
        hreq(32'h4000_1236, 4'd0, 0, 0, 4'h3);
        chk("R7", "repeat read acked", 64'(h_ack), 1);
        idle(3);

        // R6: burst of 4 with other reads while pending and while ready.
        hreq(32'h8000_0100, 4'd3, 1, 0, 4'h1);
        pwait();
        hreq(32'h8000_0200, 4'd3, 1, 0, 4'h1);
        chk("R6", "other read during fetch", 64'(h_rearb), 1);
        pserve(4, 32'h2222_0000);
        hreq(32'h8000_0100, 4'd2, 1, 0, 4'h1);
        chk("R6", "length mismatch while ready", 64'(h_rearb), 1);
        hreq(32'h8000_0104, 4'd3, 1, 0, 4'h1);
        chk("R6", "address mismatch while ready", 64'(h_rearb), 1);
        hreq(32'h8000_0100, 4'd3, 1, 0, 4'h1);
        chk("R7", "burst acked", 64'(h_ack), 1);
        hreq(32'h8000_0100, 4'd3, 1, 0, 4'h1);
        chk("R6", "read during delivery", 64'(h_rearb), 1);
        idle(4);

        // R3: I/O read keeps low address bits.
        hreq(32'hC000_0022, 4'd0, 0, 1, 4'h4);
        chk("R3", "io addr", 64'(p_addr), 64'h3000_0022);
        pwait(); pserve(1, 32'h3333_0000);
        hreq(32'hC000_0022, 4'd0, 0, 1, 4'h4);
        idle(3);

        // R4: burst longer than the buffer is capped.
        hreq(32'h0000_2000, 4'd12, 1, 0, 4'h0);
        chk("R4", "capped len", 64'(p_len), 64'(DEPTH));
        pwait(); pserve(DEPTH, 32'h4444_0000);
        hreq(32'h0000_2000, 4'd12, 1, 0, 4'h0);
        idle(DEPTH + 2);

        // R9: retry after one word, then full service.
        hreq(32'h5000_0040, 4'd2, 1, 0, 4'h0);
        pwait();
        pword(32'hDEAD_0000);
        pretry();
        chk("R9", "reissue after retry", 64'(p_req), 1);
        pwait(); pserve(3, 32'h5555_0000);
        hreq(32'h5000_0040, 4'd2, 1, 0, 4'h0);
        idle(5);

        // R10: abort, identical read errors, then new fetch.
        hreq(32'h6000_0080, 4'd0, 0, 0, 4'hF);
        pwait(); pabort();
        hreq(32'h6000_0080, 4'd0, 0, 0, 4'hF);
        chk("R10", "error after abort", 64'(h_err), 1);
        chk("R10", "no request on error", 64'(p_req), 0);
        hreq(32'h6000_0080, 4'd0, 0, 0, 4'hF);
        chk("R10", "refetch after error", 64'(h_rearb), 1);
        pwait(); pserve(1, 32'h6666_0000);
        hreq(32'h6000_0080, 4'd0, 0, 0, 4'hF);
        idle(3);
        hreq(32'h6000_0090, 4'd0, 0, 0, 4'hF);
        pwait(); pabort();
        hreq(32'h7000_0000, 4'd1, 1, 0, 4'h0);
        chk("R10", "different read after abort", 64'(h_rearb), 1);
        pwait(); pserve(2, 32'h7777_0000);
        hreq(32'h7000_0000, 4'd1, 1, 0, 4'h0);
        idle(4);

        // R8: match on the last hold edge is served.
        hreq(32'h9000_0010, 4'd1, 1, 0, 4'h0);
        pwait(); pserve(2, 32'h8888_0000);
        while (!(m_ph == 3 && m_tcnt == DISC - 2)) @(negedge clk);
        hreq(32'h9000_0010, 4'd1, 1, 0, 4'h0);
        chk("R8", "served on last hold edge", 64'(h_ack), 1);
        idle(4);

        // R8: one edge later the data is gone.
        hreq(32'hA000_0010, 4'd0, 0, 0, 4'h2);
        pwait(); pserve(1, 32'h9999_0000);
        while (!(m_ph == 3 && m_tcnt == DISC - 1)) @(negedge clk);
        hreq(32'hA000_0010, 4'd0, 0, 0, 4'h2);
        chk("R8", "discarded after hold", 64'(h_rearb), 1);
        chk("R8", "new fetch after discard", 64'(p_req), 1);
        pwait(); pserve(1, 32'hAAAA_0000);
        hreq(32'hA000_0010, 4'd0, 0, 0, 4'h2);
        idle(4);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule